// File: doc/BRIEF.md
# In-Place Exchange Sorter

This block keeps a small table of unsigned words in a private dual-port RAM and rearranges that table into ascending order without using any second buffer. The table has a fixed depth N = 2^ADDR_W. The sort walks every pair of positions (i, j) with i < j. Whenever the word at i is strictly larger than the word at j, the two words change places in one clock cycle: both RAM ports write in that cycle.

A single `mode` pin decides who owns the memory. While `mode` is low, the host owns it. The host fills the table through an address, a data word and a write strobe, and reads it back through an output that is forced to zero unless `rd_en` is high. Raising `mode` hands the table to the internal controller, which sorts it and then raises `done`. `done` stays high until the host lowers `mode` again.

The host side is a plain memory port. It has no valid/ready handshake and never back-pressures. A write is taken on every clock edge where `host_wr` is high and `mode` is low. A read address may change on every cycle.

Top module: `exchange_sorter`

## Requirements
- R1: After reset, `done` is 0 and, with `rd_en` at 0, `data_out` is 0.
- R2: With `mode`=0, `host_wr`=1 stores `host_din` at `host_addr` on the clock edge.
- R3: With `mode`=0 and `rd_en`=1, `data_out` shows the word at the `host_addr` sampled on the previous clock edge (one cycle of read latency). With `rd_en`=0, `data_out` is 0.
- R4: After a sort, the words read at addresses 0..N-1 are in non-decreasing unsigned order. Two words are swapped only when the lower-index word is strictly greater.
- R5: A sort permutes the table: every value, including repeated values, keeps its count.
- R6: `done` rises exactly N*N clock edges after the first edge that samples `mode`=1 in idle, whatever the data.
- R7: `done` stays 1 while `mode` stays 1. It falls on the first edge that samples `mode`=0, and the controller returns to idle.
- R8: While `mode`=1, `host_wr`, `host_addr` and `host_din` have no effect on the table.
- R9: Words with the top bit set sort above all words with the top bit clear (unsigned compare).
- R10: Sorting a table that is already ascending, or whose words are all equal, leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 1 | 0: host owns memory; 1: sort |
| host_addr | input | ADDR_W | Host read/write address |
| host_wr | input | 1 | Host write strobe (mode 0 only) |
| host_din | input | DATA_W | Host write data |
| rd_en | input | 1 | Output gate for read data |
| data_out | output | DATA_W | Read data, zero when gated off |
| done | output | 1 | Sort complete, held until mode falls |

## Verification
The hardest situation to create is a swap whose write lands at the same moment as the next pair's read. This happens when the inner index steps right after an exchange, and when the outer index advances and the inner index is reloaded. The stimulus reaches it with reverse-ordered and mixed tables, which force swaps on almost every compare. Tables of repeated words and of words with the top bit set test the strict, unsigned comparison. The one-cycle swap timing is then confirmed by reading the full table back and checking the exact completion time.

// File: rtl/sort_pkg.sv
package sort_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LOADJ = 3'd1,
    ST_READ  = 3'd2,
    ST_CMP   = 3'd3,
    ST_DONE  = 3'd4
  } sort_st_e;
endpackage

// File: rtl/sort_ram.sv
module sort_ram #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] addr_a,
  input  logic              we_a,
  input  logic [DATA_W-1:0] wd_a,
  output logic [DATA_W-1:0] rd_a,
  input  logic [ADDR_W-1:0] addr_b,
  input  logic              we_b,
  input  logic [DATA_W-1:0] wd_b,
  output logic [DATA_W-1:0] rd_b
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // synchronous read returns the word held before this edge's writes
  always_ff @(posedge clk) begin
    if (we_a) mem[addr_a] <= wd_a;
    if (we_b) mem[addr_b] <= wd_b;
    rd_a <= mem[addr_a];
    rd_b <= mem[addr_b];
  end
endmodule

// File: rtl/sort_counter.sv
module sort_counter #(
  parameter int W    = 3,
  parameter int LAST = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic         en,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] q,
  output logic         at_last
);
  localparam logic [W-1:0] LAST_V = W'(LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (ld) q <= ld_val;
    else if (en) q <= q + W'(1);
  end

  assign at_last = (q == LAST_V);
endmodule

// File: rtl/sort_ctrl.sv
module sort_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic mode,
  input  logic zi,
  input  logic zj,
  input  logic gt,
  output logic ld_i,
  output logic en_i,
  output logic ld_j,
  output logic en_j,
  output logic swap_we,
  output logic done
);
  import sort_pkg::*;

  sort_st_e st, st_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_nx;
  end

  always_comb begin
    st_nx   = st;
    ld_i    = 1'b0;
    en_i    = 1'b0;
    ld_j    = 1'b0;
    en_j    = 1'b0;
    swap_we = 1'b0;
    done    = 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (mode) begin
          ld_i  = 1'b1;
          st_nx = ST_LOADJ;
        end
      end
      ST_LOADJ: begin
        ld_j  = 1'b1;
        st_nx = ST_READ;
      end
      ST_READ: st_nx = ST_CMP;
      ST_CMP: begin
        swap_we = gt;
        if (!zj) begin
          en_j  = 1'b1;
          st_nx = ST_READ;
        end else if (!zi) begin
          en_i  = 1'b1;
          st_nx = ST_LOADJ;
        end else begin
          st_nx = ST_DONE;
        end
      end
      ST_DONE: begin
        done = 1'b1;
        if (!mode) st_nx = ST_IDLE;
      end
      default: st_nx = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/exchange_sorter.sv
module exchange_sorter #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_din,
  input  logic              rd_en,
  output logic [DATA_W-1:0] data_out,
  output logic              done
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [ADDR_W-1:0] idx_i, idx_j;
  logic              zi, zj;
  logic              ld_i, en_i, ld_j, en_j;
  logic              swap_we, gt;
  logic [DATA_W-1:0] rd_a, rd_b;
  logic [ADDR_W-1:0] addr_a;
  logic              we_a, we_b;
  logic [DATA_W-1:0] wd_a;

  sort_counter #(.W(ADDR_W), .LAST(DEPTH - 2)) u_cnt_i (
    .clk(clk), .rst_n(rst_n), .ld(ld_i), .en(en_i),
    .ld_val('0), .q(idx_i), .at_last(zi)
  );

  sort_counter #(.W(ADDR_W), .LAST(DEPTH - 1)) u_cnt_j (
    .clk(clk), .rst_n(rst_n), .ld(ld_j), .en(en_j),
    .ld_val(idx_i + ADDR_W'(1)), .q(idx_j), .at_last(zj)
  );

  sort_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .mode(mode), .zi(zi), .zj(zj), .gt(gt),
    .ld_i(ld_i), .en_i(en_i), .ld_j(ld_j), .en_j(en_j),
    .swap_we(swap_we), .done(done)
  );

  // port A belongs to the host in mode 0, to the i index in mode 1
  assign addr_a = mode ? idx_i   : host_addr;
  assign we_a   = mode ? swap_we : host_wr;
  assign wd_a   = mode ? rd_b    : host_din;
  assign we_b   = mode & swap_we;
  assign gt     = rd_a > rd_b;

  sort_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .clk(clk),
    .addr_a(addr_a), .we_a(we_a), .wd_a(wd_a), .rd_a(rd_a),
    .addr_b(idx_j),  .we_b(we_b), .wd_b(rd_a), .rd_b(rd_b)
  );

  assign data_out = rd_en ? rd_a : '0;
endmodule

// File: rtl/sorter_chk.sv
module sorter_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode,
  input logic              done,
  input logic              swap_we,
  input logic [DATA_W-1:0] rd_a,
  input logic [DATA_W-1:0] rd_b,
  input logic [ADDR_W-1:0] idx_i,
  input logic [ADDR_W-1:0] idx_j
);
  // R7: completion flag held while mode stays high
  a_r7_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mode) |=> done);

  // R7: completion flag released once mode falls
  a_r7_done_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !mode) |=> !done);

  // R6: completion only follows a started sort
  a_r6_done_needs_mode: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> mode);

  // R4: an exchange only when the lower word is strictly greater
  a_r4_swap_strict: assert property (@(posedge clk) disable iff (!rst_n)
    swap_we |-> (rd_a > rd_b));

  // R4: exchanged positions are ordered i < j
  a_r4_pair_order: assert property (@(posedge clk) disable iff (!rst_n)
    swap_we |-> (idx_i < idx_j));
endmodule

bind exchange_sorter sorter_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .done(done), .swap_we(swap_we),
  .rd_a(rd_a), .rd_b(rd_b), .idx_i(idx_i), .idx_j(idx_j)
);

// File: tb/sim_exchange_sorter.sv
`timescale 1ns/1ps
module sim_exchange_sorter;
  localparam int DW = 8;
  localparam int AW = 3;
  localparam int N  = 1 << AW;
  localparam int NV = 5;

  // each entry: N words, word m at bits [m*DW +: DW]
  localparam logic [N*DW-1:0] VEC [NV] = '{
    64'h05_3C_05_91_00_3C_7F_12,  // mixed with duplicates
    64'hF0_C8_80_7F_40_20_10_01,  // already ascending (word0 lowest)
    64'h01_02_03_04_05_06_07_08,  // descending by address
    64'h5A_5A_5A_5A_5A_5A_5A_5A,  // all equal
    64'h01_FF_02_80_7F_00_81_FE   // top bit mix
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic host_wr = 1'b0;
  logic [DW-1:0] host_din = '0;
  logic rd_en = 1'b0;
  logic [DW-1:0] data_out;
  logic done;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] ref_w [N];

  always #5 clk = ~clk;

  exchange_sorter #(.DATA_W(DW), .ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .mode(mode), .host_addr(host_addr),
    .host_wr(host_wr), .host_din(host_din), .rd_en(rd_en),
    .data_out(data_out), .done(done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load(input logic [N*DW-1:0] v);
    for (int m = 0; m < N; m++) begin
      @(negedge clk);
      host_addr = AW'(m); host_din = v[m*DW +: DW]; host_wr = 1'b1;
      ref_w[m] = v[m*DW +: DW];
    end
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic ref_sort();
    for (int a = 0; a < N - 1; a++)
      for (int b = a + 1; b < N; b++)
        if (ref_w[a] > ref_w[b]) begin
          logic [DW-1:0] t;
          t = ref_w[a]; ref_w[a] = ref_w[b]; ref_w[b] = t;
        end
  endtask

  task automatic readback(input string req);
    for (int m = 0; m < N; m++) begin
      @(negedge clk);
      host_addr = AW'(m); rd_en = 1'b1;
      @(negedge clk);
      chk(req, 32'(data_out), 32'(ref_w[m]));
    end
    rd_en = 1'b0;
    @(negedge clk);
    chk("R3 gated zero", 32'(data_out), 32'd0);
  endtask

  task automatic run_sort(input bit junk_writes);
    int cyc;
    @(negedge clk);
    mode = 1'b1;
    if (junk_writes) begin
      host_wr = 1'b1; host_addr = '0; host_din = 8'hEE;
    end
    cyc = 0;
    do begin
      @(posedge clk); cyc++;
      @(negedge clk);
      if (junk_writes) host_addr = host_addr + AW'(1);
    end while (!done && cyc < 1000);
    host_wr = 1'b0;
    chk("R6 cycles to done", 32'(cyc), 32'(N * N));
    repeat (3) begin
      @(negedge clk);
      chk("R7 done held", 32'(done), 32'd1);
    end
    mode = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R7 done cleared", 32'(done), 32'd0);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 done after reset", 32'(done), 32'd0);
    chk("R1 data_out gated", 32'(data_out), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      load(VEC[v]);
      if (v == 0) readback("R2 host write/R3 read");
      run_sort(v == 2);
      ref_sort();
      case (v)
        1, 3:    readback("R10 unchanged");
        2:       readback("R8 host ignored/R4");
        4:       readback("R9 unsigned");
        default: readback("R4 R5 sorted permutation");
      endcase
    end

    // R3: one-cycle latency, address change seen next cycle
    @(negedge clk);
    host_addr = AW'(N - 1); rd_en = 1'b1;
    @(negedge clk);
    host_addr = '0;
    chk("R3 latency old addr", 32'(data_out), 32'(ref_w[N-1]));
    @(negedge clk);
    chk("R3 latency new addr", 32'(data_out), 32'(ref_w[0]));
    rd_en = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule